// File: doc/BRIEF.md
# Free-running counter with compare alarm

This block keeps a 64-bit time base that never stops while out of reset. It pairs that time base with one compare slot, and software reaches both over a plain 32-bit register bus. Writes take effect on the next clock edge. Reads are combinational, so they return data in the same cycle. The counter advances once every three clock cycles. When the `fast_tick` strap is high it advances on every cycle instead.

Software reads the 64-bit value as two 32-bit halves. The value can be read at two address windows, and both windows return the same number. To get a consistent pair across a carry, software reads high, then low, then high again, and retries if the two high halves differ.

To arm an alarm, software stages the high compare half and then writes the low half. Writing the low half makes the full value live in one step. Software then sets the enable bit. The status bit sets on the first edge where the count has reached the compare value. The interrupt line is that status gated by a mask bit. Clearing enable is the only way to clear status, and so the only way to drop the interrupt.

Top module: `free_counter_alarm`

## Requirements
- R1: After reset, the counter holds the parameter `CNT_START` (0 by default), and the compare value reads 0. The control register reads 0 and `irq` is low.
- R2: With `fast_tick` low, the counter advances by exactly k over any 3k consecutive clock edges.
- R3: With `fast_tick` high, the counter advances by one on every clock edge.
- R4: The counter low half reads at 0x00008 and the high half at 0x0000C. The same halves read at 0x20008 and 0x2000C, and in any one cycle both windows return identical data.
- R5: A high, low, high read sequence in which both high reads match yields the true 64-bit count at the time of the low read, including when the low half carries into the high half.
- R6: The compare low half is at 0x10020 and the high half at 0x10024. Only bits 19:0 of the high half are kept, and its upper bits read back as 0. Reads return the live compare value.
- R7: Writing the compare high half only stages it. The live compare value changes only when the low half is written, and it then takes the staged high half together with the new low half.
- R8: The control register is at 0x1002C: bit 0 is enable, bit 1 is mask, and bit 2 is read-only status. Status sets on a clock edge where enable is 1 and the count is greater than or equal to the compare value. It then stays set while enable stays 1.
- R9: `irq` is high exactly when status is 1 and mask is 0. While masked, status still sets and reads as 1.
- R10: A control write with bit 0 equal to 0 clears status on that same edge, so `irq` is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fast_tick | input | 1 | Strap: 1 advances the counter every cycle, 0 every third cycle |
| addr | input | 18 | Byte address of the register access |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt, status gated by mask |

## Verification
The counter starts a few hundred ticks below a 32-bit carry, so the bench repeats high-low-high reads across the carry. Software that trusted a torn pair would see a count off by 2^32. The bench aims a partial compare update at a high word that would match at once if it went live early: a design without staging raises `irq` before the low word is written. Random compare distances at both tick rates catch a status that fires a cycle early or late, or one that drops while enable is still set. The mask and acknowledge cases catch a status hidden by the mask, and an enable clear that leaves `irq` high for an extra cycle.

// File: rtl/free_counter_alarm.sv
module free_counter_alarm #(
  parameter int          ADDR_W    = 18,
  parameter int          DIV       = 3,
  parameter int          CMP_HI_W  = 20,
  parameter logic [63:0] CNT_START = 64'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fast_tick,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq
);
  localparam int PRE_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int CMP_W = 32 + CMP_HI_W;
  localparam logic [ADDR_W-1:0] A_CNT_LO  = ADDR_W'('h00008);
  localparam logic [ADDR_W-1:0] A_CNT_HI  = ADDR_W'('h0000C);
  localparam logic [ADDR_W-1:0] A_ALT_LO  = ADDR_W'('h20008);
  localparam logic [ADDR_W-1:0] A_ALT_HI  = ADDR_W'('h2000C);
  localparam logic [ADDR_W-1:0] A_CMP_LO  = ADDR_W'('h10020);
  localparam logic [ADDR_W-1:0] A_CMP_HI  = ADDR_W'('h10024);
  localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'('h1002C);

  logic [PRE_W-1:0]    pre_q;
  logic [63:0]         cnt_q;
  logic [CMP_HI_W-1:0] stage_q;
  logic [CMP_W-1:0]    cmp_q;
  logic                en_q, mask_q, status_q;

  wire tick    = fast_tick | (pre_q == PRE_W'(DIV - 1));
  wire wr_lo   = wr_en && (addr == A_CMP_LO);
  wire wr_hi   = wr_en && (addr == A_CMP_HI);
  wire wr_ctrl = wr_en && (addr == A_CTRL);
  wire en_d    = wr_ctrl ? wdata[0] : en_q;
  wire hit     = cnt_q >= {{(64-CMP_W){1'b0}}, cmp_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= CNT_START;
    end else begin
      pre_q <= tick ? '0 : pre_q + PRE_W'(1);
      if (tick) cnt_q <= cnt_q + 64'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q  <= '0;
      cmp_q    <= '0;
      en_q     <= 1'b0;
      mask_q   <= 1'b0;
      status_q <= 1'b0;
    end else begin
      if (wr_hi) stage_q <= wdata[CMP_HI_W-1:0];
      if (wr_lo) cmp_q <= {stage_q, wdata};
      if (wr_ctrl) mask_q <= wdata[1];
      en_q     <= en_d;
      status_q <= en_d & (status_q | hit);
    end
  end

  always_comb begin
    case (addr)
      A_CNT_LO, A_ALT_LO: rdata = cnt_q[31:0];
      A_CNT_HI, A_ALT_HI: rdata = cnt_q[63:32];
      A_CMP_LO:           rdata = cmp_q[31:0];
      A_CMP_HI:           rdata = {{(32-CMP_HI_W){1'b0}}, cmp_q[CMP_W-1:32]};
      A_CTRL:             rdata = {29'b0, status_q, mask_q, en_q};
      default:            rdata = '0;
    endcase
  end

  assign irq = status_q & ~mask_q;

  // R3
  fast_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fast_tick |=> cnt_q == $past(cnt_q) + 64'd1);
  // R2
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 64'd1));
  // R7
  staged_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> $stable(cmp_q));
  // R8
  en_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_q |-> en_q);
  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q && !(wr_ctrl && !wdata[0])) |=> status_q);
  // R10
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !wdata[0]) |=> !irq);
endmodule

// File: tb/sim_free_counter_alarm.sv
module sim_free_counter_alarm;
  localparam logic [63:0] START = 64'h0000_0000_FFFF_FD00;
  logic clk = 0, rst_n = 0, fast_tick = 0, wr_en = 0;
  logic [17:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq;
  int checks = 0, fails = 0;
  logic [63:0] m_cnt, m_prev;
  logic [1:0] m_pre;

  free_counter_alarm #(.CNT_START(START)) u0 (
    .clk(clk), .rst_n(rst_n), .fast_tick(fast_tick), .addr(addr),
    .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #10 clk = ~clk;

  // reference count from R1..R3
  always @(posedge clk) begin
    if (!rst_n) begin m_pre <= 0; m_cnt <= START; m_prev <= START; end
    else begin
      m_prev <= m_cnt;
      if (fast_tick || m_pre == 2) begin m_pre <= 0; m_cnt <= m_cnt + 1; end
      else m_pre <= m_pre + 1;
    end
  end

  function automatic logic [51:0] cmp_of(input logic [31:0] hi, input logic [31:0] lo);
    return {hi[19:0], lo};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [17:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [17:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; #1 v = rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, v2, h1, h2, lo;
    logic [63:0] snap, cmpv;
    bit carried;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1 reset state, read during reset
    addr = 18'h00008; #1 check(rdata == START[31:0], "R1 cnt lo", rdata, START[31:0]);
    addr = 18'h0000C; #1 check(rdata == START[63:32], "R1 cnt hi", rdata, START[63:32]);
    addr = 18'h10020; #1 check(rdata == 0, "R1 cmp lo", rdata, 0);
    addr = 18'h10024; #1 check(rdata == 0, "R1 cmp hi", rdata, 0);
    addr = 18'h1002C; #1 check(rdata == 0, "R1 ctrl", rdata, 0);
    check(irq == 0, "R1 irq", irq, 0);
    rst_n = 1;

    // R2 divided rate
    for (int k = 1; k <= 6; k++) begin
      rd(18'h00008, v);
      check(v == m_cnt[31:0], "R2 model", v, m_cnt[31:0]);
      repeat (3*k - 1) @(negedge clk);
      rd(18'h00008, v2);
      check(v2 - v == k, "R2 step", v2 - v, k);
    end

    // R4 both windows agree in one cycle
    for (int i = 0; i < 5; i++) begin
      repeat ($urandom % 4) @(negedge clk);
      @(negedge clk);
      addr = 18'h00008; #1 v = rdata; addr = 18'h20008; #1 v2 = rdata;
      check(v == v2 && v == m_cnt[31:0], "R4 lo windows", v2, v);
      addr = 18'h0000C; #1 v = rdata; addr = 18'h2000C; #1 v2 = rdata;
      check(v == v2 && v == m_cnt[63:32], "R4 hi windows", v2, v);
    end

    // R5 hi-lo-hi across a carry
    carried = 0;
    for (int i = 0; i < 1500 && !(carried && h2 == 1); i++) begin
      rd(18'h0000C, h1);
      rd(18'h00008, lo); snap = m_cnt;
      rd(18'h2000C, h2);
      if (h1 != h2) carried = 1;
      else check({h1, lo} == snap, "R5 pair", {h1, lo}, snap);
    end
    check(carried && h2 == 1, "R5 carry seen", {31'b0, carried}, 1);

    // R3 fast rate
    fast_tick = 1;
    rd(18'h00008, v); repeat (9) @(negedge clk); rd(18'h00008, v2);
    check(v2 - v == 10, "R3 step", v2 - v, 10);

    // R8 R9 R10 random compare distances
    for (int t = 0; t < 10; t++) begin
      int d;
      bit rose;
      fast_tick = $urandom % 2;
      d = 8 + $urandom % 40;
      @(negedge clk);
      cmpv = m_cnt + d;
      wr(18'h10024, cmpv[63:32]);
      wr(18'h10020, cmpv[31:0]);
      wr(18'h1002C, 32'h1);
      rose = 0;
      for (int c = 0; c < 3*d + 8; c++) begin
        check(irq == (m_prev >= cmpv), "R8 status timing", irq, m_prev >= cmpv);
        if (irq) rose = 1;
        @(negedge clk); #1;
      end
      check(rose, "R9 irq raised", rose, 1);
      wr(18'h1002C, 32'h0);
      #1 check(irq == 0, "R10 ack", irq, 0);
      addr = 18'h1002C; #1 check(rdata == 0, "R10 status cleared", rdata, 0);
    end

    // R9 mask hides irq but not status
    fast_tick = 0;
    wr(18'h10024, m_cnt[63:32]);
    wr(18'h10020, 32'h0);
    wr(18'h1002C, 32'h3);
    repeat (2) @(negedge clk);
    #1 check(irq == 0, "R9 masked", irq, 0);
    addr = 18'h1002C; #1 check(rdata == 32'h7, "R9 status visible", rdata, 7);
    wr(18'h1002C, 32'h1);
    #1 check(irq == 1, "R9 unmasked", irq, 1);
    wr(18'h1002C, 32'h0);
    #1 check(irq == 0, "R10 ack after mask", irq, 0);

    // R6 high half width
    wr(18'h10024, 32'hFFFF_FFFF);
    wr(18'h10020, 32'h0000_1234);
    rd(18'h10024, v); check(v == 32'h000F_FFFF, "R6 hi trimmed", v, 32'h000F_FFFF);
    rd(18'h10020, v); check(v == 32'h1234, "R6 lo", v, 32'h1234);

    // R7 staged high half cannot trigger alone
    wr(18'h10020, 32'hFFFF_FFFF);
    wr(18'h1002C, 32'h1);
    wr(18'h10024, 32'h0);
    repeat (5) @(negedge clk);
    #1 check(irq == 0, "R7 no partial match", irq, 0);
    addr = 18'h10024; #1 check(rdata == 32'h000F_FFFF, "R7 live hi kept", rdata, 32'h000F_FFFF);
    cmpv = {12'b0, cmp_of(32'h0, 32'h0)};
    wr(18'h10020, 32'h0);
    @(negedge clk); #1 check(irq == 1, "R7 commit matches", irq, 1);
    wr(18'h1002C, 32'h0);
    #1 check(irq == 0, "R10 final ack", irq, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule